// File: doc/BRIEF.md
# Debug Control and Breakpoint Routing

This block is the debug control register bank of a small microcontroller core, paired with the logic that decides what a software breakpoint does. A 32-bit register bus reaches a halting control word, a core-register selector, a core-register data word and a monitor control word. The same bus reaches a debug fault status word and a hard fault status word. A keyed write guards the halting control word, so a stray store cannot change it. Every register update lands on the clock edge that follows the access. Reads and the bus error flag are combinational from the address.

On a breakpoint pulse the block selects one of three outcomes. It halts the core when halting debug is enabled. With halting debug disabled, it pends a debug monitor exception when the monitor is enabled and outranks the current execution priority. In every other case it escalates to a hard fault. It updates the fault status bits to record the outcome. The block does not move core registers and does not arbitrate interrupt priority. It only hands the selector to a transfer engine and pends the exceptions.

Top module: `dbg_ctrl_top`

## Requirements
- R1: Reset clears every register and every output, except halting control bit 0 (halting-debug enable), which takes the value of `dbg_attached_i`.
- R2: A write to the halting control word at offset 0xDF0 takes effect only when `wdata_i[31:16]` is 0xA05F. The accepted write stores `wdata_i[4:1]` and clears bit 0. A write with any other key leaves the word unchanged. Bit 1 is the halt request and drives `halt_o`.
- R3: A read of offset 0xDF0 returns the halting control bits [4:0], with bits [31:5] at zero.
- R4: The core-register selector at offset 0xDF4 keeps the written bits under mask 0x0001003F and presents them on `core_sel_o`. A read of 0xDF4 returns zero and raises `err_o`.
- R5: The core-register data word at offset 0xDF8 reads back all 32 written bits.
- R6: The monitor control word at offset 0xDFC keeps and returns the written bits under mask 0x010F03F1. Bit 16 is the monitor enable.
- R7: An access to any offset outside 0xD2C, 0xD30 and 0xDF0 to 0xDFC raises `err_o` and reads zero.
- R8: A breakpoint while halting debug is enabled sets the halt request, so `halt_o` is high one cycle later, and pends no exception.
- R9: A breakpoint with halting debug disabled pulses `mon_pend_o` for one cycle, one cycle later, when the monitor is enabled and `mon_prio_i` is numerically lower than `exec_prio_i`.
- R10: A breakpoint with halting debug disabled, when the monitor is disabled or `mon_prio_i` is not numerically lower than `exec_prio_i` (equal included), pulses `hf_pend_o` for one cycle, one cycle later. It also sets hard fault status bit 30.
- R11: Every breakpoint sets bit 1 of the debug fault status word at offset 0xD30.
- R12: Both fault status words clear bits written as 1. The hard fault status word at offset 0xD2C reads masked with 0xC0000003. A breakpoint setting a bit wins over a clear of that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_attached_i | input | 1 | Debugger present; seeds halting-debug enable at reset |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| err_o | output | 1 | Bus error for the current access |
| bkpt_i | input | 1 | Breakpoint event, one cycle pulse |
| exec_prio_i | input | PRIO_W | Current execution priority, lower value is higher priority |
| mon_prio_i | input | PRIO_W | Debug monitor group priority |
| halt_o | output | 1 | Core halt request |
| mon_pend_o | output | 1 | Debug monitor exception pend pulse |
| hf_pend_o | output | 1 | Hard fault pend pulse |
| core_sel_o | output | 32 | Masked core-register selector |

## Verification
A breakpoint can land in the same cycle as a bus write that clears the bit the breakpoint sets. The bench provokes this by raising `bkpt_i` together with a write-one-to-clear of debug fault status bit 1, with that bit already set. The check then reads the word back and expects bit 1 still set. The bench also confirms that the routing decision uses the enable value held before any same-cycle keyed write, and it probes the priority tie that sends a breakpoint to hard fault instead of the monitor.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_HFSR = 12'hD2C;
  localparam logic [ADDR_W-1:0] OFS_DFSR = 12'hD30;
  localparam logic [ADDR_W-1:0] OFS_HALT = 12'hDF0;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 12'hDF4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 12'hDF8;
  localparam logic [ADDR_W-1:0] OFS_MON  = 12'hDFC;

  localparam logic [15:0]       HALT_KEY  = 16'hA05F;
  localparam logic [DATA_W-1:0] SEL_MASK  = 32'h0001_003F;
  localparam logic [DATA_W-1:0] MON_MASK  = 32'h010F_03F1;
  localparam logic [DATA_W-1:0] HFSR_MASK = 32'hC000_0003;
  localparam int HALT_W      = 5;
  localparam int MON_EN_BIT  = 16;
  localparam int HF_DBG_BIT  = 30;
  localparam int DF_BKPT_BIT = 1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_HALT = 2'd1,
    ACT_MON  = 2'd2,
    ACT_ESC  = 2'd3
  } bkpt_act_e;
endpackage

// File: rtl/bkpt_route.sv
module bkpt_route
  import dbg_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bkpt_i,
  input  logic              halt_en_i,
  input  logic              mon_en_i,
  input  logic [PRIO_W-1:0] exec_prio_i,
  input  logic [PRIO_W-1:0] mon_prio_i,
  output bkpt_act_e         act_o,
  output logic              mon_pend_o,
  output logic              hf_pend_o
);
  always_comb begin
    if (!bkpt_i)                                  act_o = ACT_NONE;
    else if (halt_en_i)                           act_o = ACT_HALT;
    else if (mon_en_i && (mon_prio_i < exec_prio_i)) act_o = ACT_MON;
    else                                          act_o = ACT_ESC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_pend_o <= 1'b0;
      hf_pend_o  <= 1'b0;
    end else begin
      mon_pend_o <= (act_o == ACT_MON);
      hf_pend_o  <= (act_o == ACT_ESC);
    end
  end
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_attached_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  bkpt_act_e         act_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [HALT_W-1:0] halt_ctrl_o,
  output logic              mon_en_o,
  output logic [DATA_W-1:0] core_sel_o,
  output logic [DATA_W-1:0] dfsr_o,
  output logic [DATA_W-1:0] hfsr_o
);
  logic [HALT_W-1:0] halt_q;
  logic [DATA_W-1:0] sel_q, data_q, mon_q, dfsr_q, hfsr_q;
  logic              mapped, wr_halt, wr_sel, wr_data, wr_mon, wr_dfsr, wr_hfsr;

  always_comb begin
    unique case (addr_i)
      OFS_HFSR, OFS_DFSR, OFS_HALT, OFS_SEL, OFS_DATA, OFS_MON: mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  assign wr_halt = wr_en_i && (addr_i == OFS_HALT) && (wdata_i[31:16] == HALT_KEY);
  assign wr_sel  = wr_en_i && (addr_i == OFS_SEL);
  assign wr_data = wr_en_i && (addr_i == OFS_DATA);
  assign wr_mon  = wr_en_i && (addr_i == OFS_MON);
  assign wr_dfsr = wr_en_i && (addr_i == OFS_DFSR);
  assign wr_hfsr = wr_en_i && (addr_i == OFS_HFSR);

  // halting control: keyed write drops bit 0; breakpoint halt wins over the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= {{(HALT_W-1){1'b0}}, dbg_attached_i};
    end else begin
      if (wr_halt) halt_q <= {wdata_i[HALT_W-1:1], 1'b0};
      if (act_i == ACT_HALT) halt_q[1] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      data_q <= '0;
      mon_q  <= '0;
    end else begin
      if (wr_sel)  sel_q  <= wdata_i & SEL_MASK;
      if (wr_data) data_q <= wdata_i;
      if (wr_mon)  mon_q  <= wdata_i & MON_MASK;
    end
  end

  // fault status: write-one-to-clear, event set has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dfsr_q <= '0;
      hfsr_q <= '0;
    end else begin
      if (wr_dfsr) dfsr_q <= dfsr_q & ~wdata_i;
      if (wr_hfsr) hfsr_q <= hfsr_q & ~wdata_i;
      if (act_i != ACT_NONE) dfsr_q[DF_BKPT_BIT] <= 1'b1;
      if (act_i == ACT_ESC)  hfsr_q[HF_DBG_BIT]  <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_HALT: rdata_o = {{(DATA_W-HALT_W){1'b0}}, halt_q};
      OFS_DATA: rdata_o = data_q;
      OFS_MON:  rdata_o = mon_q;
      OFS_DFSR: rdata_o = dfsr_q;
      OFS_HFSR: rdata_o = hfsr_q & HFSR_MASK;
      default:  rdata_o = '0;
    endcase
  end

  assign err_o = ((rd_en_i || wr_en_i) && !mapped) || (rd_en_i && (addr_i == OFS_SEL));

  assign halt_ctrl_o = halt_q;
  assign mon_en_o    = mon_q[MON_EN_BIT];
  assign core_sel_o  = sel_q;
  assign dfsr_o      = dfsr_q;
  assign hfsr_o      = hfsr_q;
endmodule

// File: rtl/dbg_ctrl_top.sv
module dbg_ctrl_top
  import dbg_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_attached_i,
  input  logic [11:0]       addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic              bkpt_i,
  input  logic [PRIO_W-1:0] exec_prio_i,
  input  logic [PRIO_W-1:0] mon_prio_i,
  output logic              halt_o,
  output logic              mon_pend_o,
  output logic              hf_pend_o,
  output logic [31:0]       core_sel_o
);
  bkpt_act_e         act;
  logic [HALT_W-1:0] halt_ctrl;
  logic              mon_en;
  logic [DATA_W-1:0] dfsr, hfsr;

  bkpt_route #(.PRIO_W(PRIO_W)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bkpt_i      (bkpt_i),
    .halt_en_i   (halt_ctrl[0]),
    .mon_en_i    (mon_en),
    .exec_prio_i (exec_prio_i),
    .mon_prio_i  (mon_prio_i),
    .act_o       (act),
    .mon_pend_o  (mon_pend_o),
    .hf_pend_o   (hf_pend_o)
  );

  dbg_regs u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dbg_attached_i (dbg_attached_i),
    .addr_i         (addr_i),
    .wr_en_i        (wr_en_i),
    .rd_en_i        (rd_en_i),
    .wdata_i        (wdata_i),
    .act_i          (act),
    .rdata_o        (rdata_o),
    .err_o          (err_o),
    .halt_ctrl_o    (halt_ctrl),
    .mon_en_o       (mon_en),
    .core_sel_o     (core_sel_o),
    .dfsr_o         (dfsr),
    .hfsr_o         (hfsr)
  );

  assign halt_o = halt_ctrl[1];
endmodule

// File: rtl/dbg_ctrl_chk.sv
module dbg_ctrl_chk
  import dbg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bkpt_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [11:0]       addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [HALT_W-1:0] halt_ctrl,
  input logic [31:0]       dfsr,
  input logic [31:0]       hfsr,
  input logic              halt_o,
  input logic              mon_pend_o,
  input logic              hf_pend_o
);
  a_r2_bad_key_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_HALT && wdata_i[31:16] != HALT_KEY && !bkpt_i)
    |=> $stable(halt_ctrl));

  a_r4_sel_read_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_SEL) |-> (err_o && rdata_o == '0));

  a_r8_halt_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bkpt_i && halt_ctrl[0]) |=> (halt_o && !mon_pend_o && !hf_pend_o));

  a_r9_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mon_pend_o, hf_pend_o}));

  a_r10_esc_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_pend_o |-> hfsr[HF_DBG_BIT]);

  a_r11_dfsr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_i |=> dfsr[DF_BKPT_BIT]);
endmodule

bind dbg_ctrl_top dbg_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bkpt_i     (bkpt_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .err_o      (err_o),
  .halt_ctrl  (halt_ctrl),
  .dfsr       (dfsr),
  .hfsr       (hfsr),
  .halt_o     (halt_o),
  .mon_pend_o (mon_pend_o),
  .hf_pend_o  (hf_pend_o)
);

// File: tb/tb_dbg_ctrl_top.sv
module tb_dbg_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRIO_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0, attached = 1'b0;
  logic [11:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, bkpt = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, core_sel;
  logic err, halt, mon_pend, hf_pend;
  logic [PRIO_W-1:0] exec_prio = '0, mon_prio = '0;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_ctrl_top #(.PRIO_W(PRIO_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_attached_i(attached),
    .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .bkpt_i(bkpt),
    .exec_prio_i(exec_prio), .mon_prio_i(mon_prio),
    .halt_o(halt), .mon_pend_o(mon_pend), .hf_pend_o(hf_pend),
    .core_sel_o(core_sel)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic att);
    @(negedge clk);
    rst_ni = 1'b0; attached = att;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata; e = err;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // raise breakpoint for one cycle; outputs sampled at the following negedge
  task automatic fire(input logic [PRIO_W-1:0] ep, input logic [PRIO_W-1:0] mp,
                      output logic h, output logic m, output logic f);
    @(negedge clk);
    exec_prio = ep; mon_prio = mp; bkpt = 1'b1;
    @(negedge clk);
    bkpt = 1'b0;
    h = halt; m = mon_pend; f = hf_pend;
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic e;
    do_reset(1'b0);
    bus_rd(12'hDF0, d, e); chk("R1 halt ctrl detached", d, 32'h0);
    bus_rd(12'hD30, d, e); chk("R1 dfsr", d, 32'h0);
    bus_rd(12'hD2C, d, e); chk("R1 hfsr", d, 32'h0);
    bus_rd(12'hDFC, d, e); chk("R1 mon ctl", d, 32'h0);
    chk("R1 outputs", {28'h0, halt, mon_pend, hf_pend, err}, 32'h0);
  endtask

  task automatic t_plain_regs();
    logic [31:0] d; logic e;
    bus_wr(12'hDF8, 32'hDEADBEEF);
    bus_rd(12'hDF8, d, e); chk("R5 data rw", d, 32'hDEADBEEF);
    bus_wr(12'hDFC, 32'hFFFFFFFF);
    bus_rd(12'hDFC, d, e); chk("R6 mon mask", d, 32'h010F03F1);
    bus_wr(12'hDF4, 32'hFFFFFFFF);
    chk("R4 selector mask", core_sel, 32'h0001003F);
    bus_rd(12'hDF4, d, e); chk("R4 selector read zero", d, 32'h0);
    chk("R4 selector read err", {31'h0, e}, 32'h1);
    bus_rd(12'hD00, d, e); chk("R7 unmapped err", {31'h0, e}, 32'h1);
    chk("R7 unmapped zero", d, 32'h0);
    bus_rd(12'hDF8, d, e); chk("R7 mapped no err", {31'h0, e}, 32'h0);
  endtask

  task automatic t_halt_key();
    logic [31:0] d; logic e;
    bus_wr(12'hDF0, 32'h1234001E);
    bus_rd(12'hDF0, d, e); chk("R2 wrong key ignored", d, 32'h0);
    bus_wr(12'hDF0, 32'hA05F001F);
    bus_rd(12'hDF0, d, e); chk("R2 R3 keyed write bit0 dropped", d, 32'h0000001E);
    chk("R2 halt_o follows bit1", {31'h0, halt}, 32'h1);
    bus_wr(12'hDF0, 32'hA05FFFE0);
    bus_rd(12'hDF0, d, e); chk("R3 upper bits read zero", d, 32'h0);
  endtask

  task automatic t_escalate();
    logic [31:0] d; logic e, h, m, f;
    bus_wr(12'hDFC, 32'h0);
    fire(8'd5, 8'd2, h, m, f);
    chk("R10 monitor off escalates", {29'h0, h, m, f}, 32'h1);
    bus_rd(12'hD2C, d, e); chk("R10 hfsr debug event", d, 32'h40000000);
    bus_rd(12'hD30, d, e); chk("R11 dfsr bkpt bit", d, 32'h2);
    bus_wr(12'hD2C, 32'h40000000);
    bus_rd(12'hD2C, d, e); chk("R12 hfsr w1c", d, 32'h0);
    bus_wr(12'hD30, 32'h2);
    bus_rd(12'hD30, d, e); chk("R12 dfsr w1c", d, 32'h0);
  endtask

  task automatic t_monitor();
    logic [31:0] d; logic e, h, m, f;
    bus_wr(12'hDFC, 32'h00010000);
    fire(8'd5, 8'd2, h, m, f);
    chk("R9 monitor pend", {29'h0, h, m, f}, 32'h2);
    @(negedge clk);
    chk("R9 pend one cycle", {30'h0, mon_pend, hf_pend}, 32'h0);
    bus_rd(12'hD2C, d, e); chk("R9 hfsr untouched", d, 32'h0);
    fire(8'd3, 8'd3, h, m, f);
    chk("R10 equal priority escalates", {29'h0, h, m, f}, 32'h1);
    fire(8'd1, 8'd4, h, m, f);
    chk("R10 lower priority escalates", {29'h0, h, m, f}, 32'h1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d; logic e;
    // dfsr bit1 already set from earlier events; clear and set collide
    @(negedge clk);
    addr = 12'hD30; wdata = 32'h2; wr_en = 1'b1; bkpt = 1'b1;
    exec_prio = 8'd5; mon_prio = 8'd2;
    @(negedge clk);
    wr_en = 1'b0; bkpt = 1'b0;
    bus_rd(12'hD30, d, e); chk("R12 set wins over clear", d, 32'h2);
  endtask

  task automatic t_halting();
    logic [31:0] d; logic e, h, m, f;
    do_reset(1'b1);
    bus_rd(12'hDF0, d, e); chk("R1 attached enable", d, 32'h1);
    bus_wr(12'hDFC, 32'h00010000);
    fire(8'd5, 8'd2, h, m, f);
    chk("R8 halt no pend", {29'h0, h, m, f}, 32'h4);
    bus_rd(12'hDF0, d, e); chk("R8 halt ctrl", d, 32'h3);
    bus_rd(12'hD30, d, e); chk("R11 dfsr on halt", d, 32'h2);
    // keyed write releasing halt in same cycle as breakpoint: old enable routes to halt
    @(negedge clk);
    addr = 12'hDF0; wdata = 32'hA05F0000; wr_en = 1'b1; bkpt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bkpt = 1'b0;
    chk("R8 same-cycle release", {29'h0, halt, mon_pend, hf_pend}, 32'h4);
    bus_rd(12'hDF0, d, e); chk("R2 R8 enable cleared halt kept", d, 32'h2);
  endtask

  initial begin
    t_reset_state();
    t_plain_regs();
    t_halt_key();
    t_escalate();
    t_monitor();
    t_same_cycle();
    t_halting();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule